// File: doc/BRIEF.md
# Twin-Mask Vector Element Sequencer

This block walks the element loop of a single vector operation. After a start pulse it captures an element count, one mask for the source side and one for the destination side, flags that mark each operand as scalar or vector, and optional starting positions for both sides. It then offers one (source index, destination index) pair per cycle until either side runs out of enabled elements. After that it pulses done and clears both position counters.

The two sides step independently. Each side moves to its next enabled element, so a sparse source mask packs the selected elements into consecutive destination slots (compress), and a sparse destination mask spreads consecutive source elements into the selected slots (expand). When both masks are sparse, both behaviours combine.

Each mask can be built in one of several ways:
- all ones;
- a register value, or its bitwise inverse;
- a single set bit at a position given by a register value;
- one chosen bit from each 4-bit condition field, optionally inverted.

The issue stage consumes each pair with an advance strobe. Because the starting positions can be loaded, an interrupted loop can resume where it stopped.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, issue_valid_o and done_o are 0, and src_step_o and dst_step_o are 0.
- R2: With a length of 0, no pair is issued and done_o pulses for one cycle. The step outputs then read 0, whatever the starting steps were.
- R3: With mask mode 0 (all ones) on both sides and both operands vector, the pairs are (k,k) for k = 0 .. length-1, one per accepted cycle. Then done_o pulses and both steps read 0.
- R4: A sparse source mask with a full destination mask yields the set source positions in ascending order, paired with destination indices 0, 1, 2 and so on (compress).
- R5: A sparse destination mask with a full source mask pairs source indices 0, 1, 2 and so on with the set destination positions in ascending order (expand).
- R6: With both masks sparse, each side steps to its own next set bit. The loop ends when either side has no set bit left below the length, and after each accepted pair each step reads one past the index just issued.
- R7: Mask mode 1 uses the register value, mode 2 uses its bitwise inverse, and mode 3 uses a single bit at position reg[5:0].
- R8: Mode 4 takes element k's bit from cr_i[4k+sel], and mode 5 inverts that bit. The two sides may use different sel values.
- R9: With a scalar source, src_idx_o is 0 on every issued pair, while the destination still steps.
- R10: With a scalar destination, dst_idx_o is 0. The loop ends with done_o in the cycle after the first accepted pair.
- R11: Nonzero starting steps resume the loop from those positions. Set bits below them are skipped.
- R12: While advance_i is low, a valid pair stays valid and unchanged.
- R13: A start pulse while a loop is running is ignored, and the running sequence is unchanged.
- R14: Mask bits at or above the length are never issued, and every issued vector index is below the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the configuration and begin a loop |
| vl_i | input | 7 | Element count, 0 to 64 (larger values are clamped) |
| src_mode_i | input | 3 | Source mask mode (0 all, 1 reg, 2 ~reg, 3 one-hot, 4 cond, 5 ~cond) |
| src_reg_i | input | 64 | Source mask register value |
| src_sel_i | input | 2 | Bit chosen within each condition field for the source side |
| dst_mode_i | input | 3 | Destination mask mode, same encoding |
| dst_reg_i | input | 64 | Destination mask register value |
| dst_sel_i | input | 2 | Bit chosen within each condition field for the destination side |
| cr_i | input | 256 | 64 condition fields of 4 bits; field k is bits [4k+3:4k] |
| src_vec_i | input | 1 | 1 = source is a vector, 0 = scalar |
| dst_vec_i | input | 1 | 1 = destination is a vector, 0 = scalar |
| src_init_i | input | 6 | Starting source step |
| dst_init_i | input | 6 | Starting destination step |
| advance_i | input | 1 | Consume the current pair |
| issue_valid_o | output | 1 | A pair is available |
| src_idx_o | output | 6 | Source element index |
| dst_idx_o | output | 6 | Destination element index |
| done_o | output | 1 | One-cycle pulse when the loop ends |
| src_step_o | output | 7 | Current source step |
| dst_step_o | output | 7 | Current destination step |

## Verification
The stepping logic is tried with several patterns:
- full masks, which separate plain lockstep from any masking;
- a sparse source only and a sparse destination only, which tell compress apart from expand;
- complementary twin masks, which show that the two sides are independent;
- condition-field masks where each side picks a different bit, which catch a shared selection.

Further runs target specific faults. Starting steps above set bits catch a loop that restarts at zero. One-hot and length-clipped masks catch off-by-one search limits. Scalar operands, stalls and a stray start while busy confirm that indices hold and that the loop ends where it should.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    MSK_ALL     = 3'd0,
    MSK_REG     = 3'd1,
    MSK_REG_INV = 3'd2,
    MSK_ONEHOT  = 3'd3,
    MSK_CR      = 3'd4,
    MSK_CR_INV  = 3'd5
  } msk_mode_e;
endpackage

// File: rtl/vseq_mask_gen.sv
module vseq_mask_gen #(
  parameter int N  = 64,
  parameter int FW = 4,
  localparam int IW = $clog2(N),
  localparam int SW = $clog2(FW)
) (
  input  logic [2:0]      mode_i,
  input  logic [N-1:0]    reg_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [FW*N-1:0] cr_i,
  output logic [N-1:0]    mask_o
);
  import vseq_pkg::*;

  logic [N-1:0] cr_bits;
  logic [N-1:0] one_hot;

  // one chosen bit per condition field
  always_comb begin
    for (int k = 0; k < N; k++) cr_bits[k] = cr_i[FW*k + int'(sel_i)];
  end

  assign one_hot = {{(N-1){1'b0}}, 1'b1} << reg_i[IW-1:0];

  always_comb begin
    unique case (msk_mode_e'(mode_i))
      MSK_REG:     mask_o = reg_i;
      MSK_REG_INV: mask_o = ~reg_i;
      MSK_ONEHOT:  mask_o = one_hot;
      MSK_CR:      mask_o = cr_bits;
      MSK_CR_INV:  mask_o = ~cr_bits;
      default:     mask_o = '1;
    endcase
  end
endmodule

// File: rtl/vseq_find_next.sv
module vseq_find_next #(
  parameter int N  = 64,
  localparam int STEP_W = $clog2(N) + 1
) (
  input  logic [N-1:0]      mask_i,
  input  logic [STEP_W-1:0] from_i,
  input  logic [STEP_W-1:0] lim_i,
  output logic              found_o,
  output logic [STEP_W-1:0] idx_o
);
  // lowest set bit in [from_i, lim_i)
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i] && (STEP_W'(i) >= from_i) && (STEP_W'(i) < lim_i)) begin
        found_o = 1'b1;
        idx_o   = STEP_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int N  = 64,
  parameter int FW = 4,
  localparam int IW     = $clog2(N),
  localparam int STEP_W = IW + 1,
  localparam int SW     = $clog2(FW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [2:0]        src_mode_i,
  input  logic [N-1:0]      src_reg_i,
  input  logic [SW-1:0]     src_sel_i,
  input  logic [2:0]        dst_mode_i,
  input  logic [N-1:0]      dst_reg_i,
  input  logic [SW-1:0]     dst_sel_i,
  input  logic [FW*N-1:0]   cr_i,
  input  logic              src_vec_i,
  input  logic              dst_vec_i,
  input  logic [IW-1:0]     src_init_i,
  input  logic [IW-1:0]     dst_init_i,
  input  logic              advance_i,
  output logic              issue_valid_o,
  output logic [IW-1:0]     src_idx_o,
  output logic [IW-1:0]     dst_idx_o,
  output logic              done_o,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o
);
  logic              busy_q, done_q;
  logic [STEP_W-1:0] vl_q, src_step_q, dst_step_q;
  logic [N-1:0]      src_mask_q, dst_mask_q;
  logic              src_vec_q, dst_vec_q;

  logic [N-1:0]      src_mask_d, dst_mask_d;
  logic              src_found, dst_found;
  logic [STEP_W-1:0] src_nxt, dst_nxt;
  logic              pair_ok, accept, finish, take_start;

  vseq_mask_gen #(.N(N), .FW(FW)) src_gen_i (
    .mode_i(src_mode_i), .reg_i(src_reg_i), .sel_i(src_sel_i),
    .cr_i(cr_i), .mask_o(src_mask_d)
  );

  vseq_mask_gen #(.N(N), .FW(FW)) dst_gen_i (
    .mode_i(dst_mode_i), .reg_i(dst_reg_i), .sel_i(dst_sel_i),
    .cr_i(cr_i), .mask_o(dst_mask_d)
  );

  vseq_find_next #(.N(N)) src_find_i (
    .mask_i(src_mask_q), .from_i(src_step_q), .lim_i(vl_q),
    .found_o(src_found), .idx_o(src_nxt)
  );

  vseq_find_next #(.N(N)) dst_find_i (
    .mask_i(dst_mask_q), .from_i(dst_step_q), .lim_i(vl_q),
    .found_o(dst_found), .idx_o(dst_nxt)
  );

  assign pair_ok    = busy_q & src_found & dst_found;
  assign accept     = pair_ok & advance_i;
  // scalar destination stops after its single write
  assign finish     = busy_q & (~pair_ok | (accept & ~dst_vec_q));
  assign take_start = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      vl_q       <= '0;
      src_step_q <= '0;
      dst_step_q <= '0;
      src_mask_q <= '0;
      dst_mask_q <= '0;
      src_vec_q  <= 1'b0;
      dst_vec_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (take_start) begin
        busy_q     <= 1'b1;
        vl_q       <= (vl_i > STEP_W'(N)) ? STEP_W'(N) : vl_i;
        src_mask_q <= src_mask_d;
        dst_mask_q <= dst_mask_d;
        src_vec_q  <= src_vec_i;
        dst_vec_q  <= dst_vec_i;
        src_step_q <= {1'b0, src_init_i};
        dst_step_q <= {1'b0, dst_init_i};
      end else if (finish) begin
        busy_q     <= 1'b0;
        src_step_q <= '0;
        dst_step_q <= '0;
      end else if (accept) begin
        src_step_q <= src_nxt + 1'b1;
        dst_step_q <= dst_nxt + 1'b1;
      end
    end
  end

  assign issue_valid_o = pair_ok;
  assign src_idx_o     = src_vec_q ? src_nxt[IW-1:0] : '0;
  assign dst_idx_o     = dst_vec_q ? dst_nxt[IW-1:0] : '0;
  assign done_o        = done_q;
  assign src_step_o    = src_step_q;
  assign dst_step_o    = dst_step_q;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int IW = 6,
  localparam int STEP_W = IW + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              advance_i,
  input logic              issue_valid_o,
  input logic [IW-1:0]     src_idx_o,
  input logic [IW-1:0]     dst_idx_o,
  input logic              done_o,
  input logic [STEP_W-1:0] src_step_o,
  input logic [STEP_W-1:0] dst_step_o,
  input logic [STEP_W-1:0] vl_q,
  input logic              src_vec_q,
  input logic              dst_vec_q
);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_steps_cleared_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (src_step_o == '0) && (dst_step_o == '0));

  assert_step_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && advance_i && dst_vec_q |=>
      dst_step_o == STEP_W'($past(dst_idx_o)) + 1'b1);

  assert_scalar_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && !src_vec_q |-> src_idx_o == '0);

  assert_scalar_dst_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && advance_i && !dst_vec_q |=> done_o && !issue_valid_o);

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && !advance_i |=>
      issue_valid_o && $stable(src_idx_o) && $stable(dst_idx_o));

  assert_idx_in_range_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && dst_vec_q |-> STEP_W'(dst_idx_o) < vl_q);

  assert_no_issue_on_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !issue_valid_o);
endmodule

bind vec_elem_seq vseq_checker #(.IW(IW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .advance_i(advance_i),
  .issue_valid_o(issue_valid_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
  .done_o(done_o), .src_step_o(src_step_o), .dst_step_o(dst_step_o),
  .vl_q(vl_q), .src_vec_q(src_vec_q), .dst_vec_q(dst_vec_q)
);

// File: tb/vec_elem_seq_tb_top.sv
`timescale 1ns/1ps
module vec_elem_seq_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [6:0]   vl_i = '0;
  logic [2:0]   src_mode_i = '0, dst_mode_i = '0;
  logic [63:0]  src_reg_i = '0, dst_reg_i = '0;
  logic [1:0]   src_sel_i = '0, dst_sel_i = '0;
  logic [255:0] cr_i = '0;
  logic         src_vec_i = 1'b1, dst_vec_i = 1'b1;
  logic [5:0]   src_init_i = '0, dst_init_i = '0;
  logic         advance_i = 1'b0;
  logic         issue_valid_o, done_o;
  logic [5:0]   src_idx_o, dst_idx_o;
  logic [6:0]   src_step_o, dst_step_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_s[64];
  int exp_d[64];
  int exp_n;
  int stall_at;
  bit poke;

  always #2 clk_i = ~clk_i;

  vec_elem_seq dut_i (.*);

  task automatic check(string req, bit ok, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(logic [2:0] m, logic [63:0] r, logic [1:0] s);
    logic [63:0] c;
    for (int k = 0; k < 64; k++) c[k] = cr_i[4*k + s];
    case (m)
      3'd1: return r;
      3'd2: return ~r;
      3'd3: return 64'd1 << r[5:0];
      3'd4: return c;
      3'd5: return ~c;
      default: return '1;
    endcase
  endfunction

  task automatic build_expected();
    logic [63:0] sm, dm;
    int s, d, vl;
    sm = bmask(src_mode_i, src_reg_i, src_sel_i);
    dm = bmask(dst_mode_i, dst_reg_i, dst_sel_i);
    vl = (vl_i > 64) ? 64 : int'(vl_i);
    s = src_init_i; d = dst_init_i; exp_n = 0;
    forever begin
      while (s < vl && !sm[s]) s++;
      while (d < vl && !dm[d]) d++;
      if (s >= vl || d >= vl) break;
      exp_s[exp_n] = src_vec_i ? s : 0;
      exp_d[exp_n] = dst_vec_i ? d : 0;
      exp_n++;
      if (!dst_vec_i) break;
      s++; d++;
    end
  endtask

  task automatic defaults();
    vl_i = 7'd8; src_mode_i = 3'd0; dst_mode_i = 3'd0;
    src_reg_i = '0; dst_reg_i = '0; src_sel_i = '0; dst_sel_i = '0;
    src_vec_i = 1'b1; dst_vec_i = 1'b1; src_init_i = '0; dst_init_i = '0;
    stall_at = -1; poke = 1'b0;
  endtask

  // start, consume every pair, compare with the model, check step clear
  task automatic run(string req);
    int k = 0;
    int cyc = 0;
    bit seen_done = 1'b0;
    logic [6:0] keep_vl;
    build_expected();
    keep_vl = vl_i;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    advance_i = 1'b1;
    while (cyc < 300) begin
      if (done_o) begin seen_done = 1'b1; break; end
      if (issue_valid_o) begin
        if (k == stall_at) begin
          int hs = src_idx_o;
          int hd = dst_idx_o;
          advance_i = 1'b0;
          repeat (3) @(negedge clk_i);
          check({req, " stall hold"}, issue_valid_o && src_idx_o == hs && dst_idx_o == hd,
                {src_idx_o, dst_idx_o}, {hs[5:0], hd[5:0]});
          advance_i = 1'b1;
        end
        if (k < exp_n)
          check({req, " pair"}, int'(src_idx_o) == exp_s[k] && int'(dst_idx_o) == exp_d[k],
                src_idx_o * 100 + dst_idx_o, exp_s[k] * 100 + exp_d[k]);
        else
          check({req, " extra pair"}, 1'b0, k, exp_n);
        if (poke && k == 0) begin
          start_i = 1'b1;
          vl_i = 7'd1;
        end
        k++;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      vl_i = keep_vl;
      cyc++;
    end
    advance_i = 1'b0;
    check({req, " done seen"}, seen_done, seen_done, 1);
    check({req, " pair count"}, k == exp_n, k, exp_n);
    check({req, " steps cleared"}, src_step_o == 0 && dst_step_o == 0,
          src_step_o * 128 + dst_step_o, 0);
    @(negedge clk_i);
    check({req, " done one cycle"}, !done_o, done_o, 0);
  endtask

  task automatic t_reset();
    check("R1 reset valid/done", !issue_valid_o && !done_o, {issue_valid_o, done_o}, 0);
    check("R1 reset steps", src_step_o == 0 && dst_step_o == 0, src_step_o + dst_step_o, 0);
  endtask

  task automatic t_vl_zero();
    defaults(); vl_i = 7'd0; src_init_i = 6'd3; dst_init_i = 6'd5;
    run("R2 length zero");
  endtask

  task automatic t_plain();
    defaults(); vl_i = 7'd5; run("R3 full masks");
    defaults(); vl_i = 7'd64; run("R3 full length");
  endtask

  task automatic t_compress();
    defaults(); src_mode_i = 3'd1; src_reg_i = 64'b1011_0101; run("R4 compress");
  endtask

  task automatic t_expand();
    defaults(); dst_mode_i = 3'd1; dst_reg_i = 64'b1010_0110; run("R5 expand");
  endtask

  task automatic t_twin();
    defaults(); vl_i = 7'd3; src_mode_i = 3'd1; src_reg_i = 64'b101;
    dst_mode_i = 3'd2; dst_reg_i = 64'b101; run("R6 twin complement");
    defaults(); vl_i = 7'd16; src_mode_i = 3'd1; src_reg_i = 64'hC3A5;
    dst_mode_i = 3'd1; dst_reg_i = 64'h5F0A; run("R6 twin sparse");
  endtask

  task automatic t_modes();
    defaults(); vl_i = 7'd4; dst_mode_i = 3'd3; dst_reg_i = 64'd2;
    run("R7 one-hot destination");
    defaults(); vl_i = 7'd6; src_mode_i = 3'd3; src_reg_i = 64'd2;
    run("R7 one-hot source");
    defaults(); vl_i = 7'd12; src_mode_i = 3'd2; src_reg_i = 64'h0F0;
    run("R7 inverted register");
  endtask

  task automatic t_cr();
    for (int k = 0; k < 64; k++) cr_i[4*k +: 4] = 4'((k * 7 + 3) ^ (k >> 1));
    defaults(); vl_i = 7'd20; src_mode_i = 3'd4; src_sel_i = 2'd2;
    dst_mode_i = 3'd5; dst_sel_i = 2'd0; run("R8 cond fields diff bits");
    defaults(); vl_i = 7'd20; src_mode_i = 3'd4; src_sel_i = 2'd1;
    run("R8 cond compress");
  endtask

  task automatic t_scalar();
    defaults(); src_vec_i = 1'b0; vl_i = 7'd5; dst_mode_i = 3'd1; dst_reg_i = 64'b11010;
    run("R9 scalar source");
    defaults(); dst_vec_i = 1'b0; src_mode_i = 3'd1; src_reg_i = 64'b1100;
    run("R10 scalar destination");
  endtask

  task automatic t_resume();
    defaults(); vl_i = 7'd10; src_mode_i = 3'd1; src_reg_i = 64'b11_0111_0111;
    src_init_i = 6'd2; dst_init_i = 6'd4; run("R11 resume mid loop");
  endtask

  task automatic t_stall();
    defaults(); vl_i = 7'd6; src_mode_i = 3'd1; src_reg_i = 64'b110110;
    stall_at = 2; run("R12 stall");
  endtask

  task automatic t_busy_start();
    defaults(); vl_i = 7'd7; poke = 1'b1; run("R13 start while busy");
  endtask

  task automatic t_clip();
    defaults(); vl_i = 7'd3; src_mode_i = 3'd1; src_reg_i = 64'hFFFF_0000_0000_00F5;
    dst_mode_i = 3'd1; dst_reg_i = 64'hF0; run("R14 bits beyond length");
    defaults(); vl_i = 7'd4; src_mode_i = 3'd1; src_reg_i = 64'h1D; run("R14 clipped compress");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_vl_zero();
    t_plain();
    t_compress();
    t_expand();
    t_twin();
    t_modes();
    t_cr();
    t_scalar();
    t_resume();
    t_stall();
    t_busy_start();
    t_clip();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule